// File: doc/BRIEF.md
# Reference-Vector Link Error Checker

This block sits on the receive side of a test link and scores the traffic against a frame of known 128-bit test words. A short reference table of `DEPTH` words (30 by default) is produced on chip; the sender side walks the same table, so both ends agree on which word should arrive at each position. Each arriving word is compared with the reference word for the current table position, and the position then moves on by one, returning to the start after the last entry.

Three statistics are kept. The first counts the words scored. The second counts the words that differed from their reference. The third totals the differing bits. The bit error rate follows as bits in error divided by 128 times the words scored. A synchronous clear zeroes all three statistics and the table position in one cycle, so that a new measurement can start. A one-cycle pulse marks the scoring of the last table entry.

Words arrive on a valid/ready stream. The sink only pushes back while `clear` is high: `in_ready` is the inverse of `clear`. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. The sender must hold `in_data` steady while `in_valid` is high and `in_ready` is low. Cycles without a transfer leave every output unchanged.

Top module: `bert_checker`

## Requirements
- R1: While `rst_n` is low, and after it is released, `vec_addr`, `words_checked`, `word_errors`, `bit_errors` and `frame_done` are all zero.
- R2: `in_ready` is high exactly when `clear` is low. A cycle with no transfer (`in_valid` low, or `clear` high) does not change `vec_addr` or any counter, except for the reset done by clear in R9.
- R3: The reference word for table position a has four 32-bit lanes, with lane k occupying bits [32k+31:32k]. Each lane equals ((a+1)·0x9E3779B9) XOR (k·0x7F4A7C15), taken modulo 2^32.
- R4: Each accepted word raises `words_checked` by one. The result shows after the accepting edge.
- R5: `word_errors` rises by one for an accepted word that differs from the reference word in any bit. It stays the same when the word matches.
- R6: `bit_errors` rises by the number of ones in (received XOR reference) for each accepted word.
- R7: `vec_addr` advances by one per accepted word and goes from `DEPTH-1` to 0. `frame_done` is high for exactly the one cycle after the edge that accepts the word at position `DEPTH-1`.
- R8: Each counter stops at all ones instead of wrapping. If an addition to `bit_errors` would overflow, the counter holds all ones.
- R9: A high `clear` at an edge sets `vec_addr` and all three counters to zero at that edge. No word is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous restart of the position and the statistics |
| in_valid | input | 1 | Received word present |
| in_ready | output | 1 | Checker can accept a word |
| in_data | input | 128 | Received word |
| vec_addr | output | 5 | Current reference table position |
| frame_done | output | 1 | Pulse after the last table entry is scored |
| words_checked | output | WCNT_W (16) | Words scored |
| word_errors | output | WCNT_W (16) | Words with at least one bit wrong |
| bit_errors | output | BCNT_W (24) | Total wrong bits |

## Verification
On every cycle the assertions check the following:
- the position stays below `DEPTH`;
- the position wraps and raises the frame pulse after the last entry;
- the pulse never lasts two cycles;
- the word count steps by one per transfer;
- idle cycles hold state;
- the error counter never decreases except on clear;
- the error count never exceeds the word count;
- clear empties everything.

Two things can only be shown by the bench's scenarios, through its cycle-by-cycle model: that the reference words match the R3 formula, and that the bit totals equal the popcount of the difference. The same applies to saturation after many all-wrong words and to a clear that arrives in the middle of a frame while a word is being offered.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int LANE_W = 32;
  localparam logic [31:0] ADDR_MULT = 32'h9E3779B9;
  localparam logic [31:0] LANE_MULT = 32'h7F4A7C15;

  function automatic logic [31:0] ref_lane(input int unsigned pos, input int unsigned lane);
    logic [31:0] a1;
    logic [31:0] k;
    a1 = 32'(pos + 1);
    k  = 32'(lane);
    return (a1 * ADDR_MULT) ^ (k * LANE_MULT);
  endfunction
endpackage

// File: rtl/bert_vec_rom.sv
module bert_vec_rom #(
  parameter int DEPTH  = 30,
  parameter int DATA_W = 128,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANES  = DATA_W / bert_pkg::LANE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      word[k*bert_pkg::LANE_W +: bert_pkg::LANE_W] =
        bert_pkg::ref_lane(int'(addr), k);
    end
  end
endmodule

// File: rtl/bert_popcount.sv
module bert_popcount #(
  parameter int DATA_W = 128,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic [DATA_W-1:0] bits,
  output logic [CNT_W-1:0]  ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + CNT_W'(bits[i]);
    end
  end
endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
  parameter int W     = 16,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  logic [W:0] sum;

  always_comb sum = {1'b0, cnt} + (W+1)'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (en)       cnt <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/bert_checker.sv
module bert_checker #(
  parameter int DEPTH  = 30,
  parameter int DATA_W = 128,
  parameter int WCNT_W = 16,
  parameter int BCNT_W = 24,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PC_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              frame_done,
  output logic [WCNT_W-1:0] words_checked,
  output logic [WCNT_W-1:0] word_errors,
  output logic [BCNT_W-1:0] bit_errors
);
  logic [DATA_W-1:0] ref_word;
  logic [DATA_W-1:0] diff;
  logic [PC_W-1:0]   diff_ones;
  logic              accept;
  logic              last_pos;
  logic              miss;

  assign in_ready = ~clear;
  assign accept   = in_valid & in_ready;
  assign last_pos = (vec_addr == ADDR_W'(DEPTH - 1));
  assign diff     = in_data ^ ref_word;
  assign miss     = |diff;

  bert_vec_rom #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rom (
    .addr (vec_addr),
    .word (ref_word)
  );

  bert_popcount #(.DATA_W(DATA_W)) u_pop (
    .bits (diff),
    .ones (diff_ones)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_addr   <= '0;
      frame_done <= 1'b0;
    end else if (clear) begin
      vec_addr   <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= accept & last_pos;
      if (accept) vec_addr <= last_pos ? '0 : vec_addr + 1'b1;
    end
  end

  bert_sat_counter #(.W(WCNT_W), .INC_W(1)) u_words (
    .clk (clk), .rst_n (rst_n), .clr (clear),
    .en (accept), .inc (1'b1), .cnt (words_checked)
  );

  bert_sat_counter #(.W(WCNT_W), .INC_W(1)) u_werr (
    .clk (clk), .rst_n (rst_n), .clr (clear),
    .en (accept & miss), .inc (1'b1), .cnt (word_errors)
  );

  bert_sat_counter #(.W(BCNT_W), .INC_W(PC_W)) u_berr (
    .clk (clk), .rst_n (rst_n), .clr (clear),
    .en (accept), .inc (diff_ones), .cnt (bit_errors)
  );
endmodule

// File: rtl/bert_checker_sva.sv
module bert_checker_sva #(
  parameter int DEPTH  = 30,
  parameter int WCNT_W = 16,
  parameter int BCNT_W = 24,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              frame_done,
  input logic [WCNT_W-1:0] words_checked,
  input logic [WCNT_W-1:0] word_errors,
  input logic [BCNT_W-1:0] bit_errors
);
  logic xfer;
  assign xfer = in_valid && in_ready;

  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr < ADDR_W'(DEPTH));

  a_r7_wrap_done: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && vec_addr == ADDR_W'(DEPTH - 1)) |=> (vec_addr == '0 && frame_done));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && words_checked != '1) |=> words_checked == $past(words_checked) + 1'b1);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clear) |=> ($stable(vec_addr) && $stable(words_checked)
                               && $stable(word_errors) && $stable(bit_errors)));

  a_r8_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> word_errors >= $past(word_errors));

  a_r5_err_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    word_errors <= words_checked);

  a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vec_addr == '0 && words_checked == '0 && word_errors == '0
               && bit_errors == '0 && !frame_done));
endmodule

bind bert_checker bert_checker_sva #(
  .DEPTH(DEPTH), .WCNT_W(WCNT_W), .BCNT_W(BCNT_W), .ADDR_W(ADDR_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
  .in_ready(in_ready), .vec_addr(vec_addr), .frame_done(frame_done),
  .words_checked(words_checked), .word_errors(word_errors),
  .bit_errors(bit_errors)
);

// File: tb/bert_checker_test.sv
module bert_checker_test;
  localparam int DEPTH  = 30;
  localparam int WCNT_W = 8;
  localparam int BCNT_W = 12;
  localparam int WMAX   = (1 << WCNT_W) - 1;
  localparam int BMAX   = (1 << BCNT_W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [4:0]   vec_addr;
  logic         frame_done;
  logic [WCNT_W-1:0] words_checked;
  logic [WCNT_W-1:0] word_errors;
  logic [BCNT_W-1:0] bit_errors;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int m_addr = 0, m_words = 0, m_werr = 0, m_berr = 0;
  bit m_done = 0;

  bert_checker #(.DEPTH(DEPTH), .DATA_W(128), .WCNT_W(WCNT_W), .BCNT_W(BCNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .vec_addr(vec_addr),
    .frame_done(frame_done), .words_checked(words_checked),
    .word_errors(word_errors), .bit_errors(bit_errors)
  );

  always #10 clk = ~clk;

  // R3: reference word computed from the stated lane formula
  function automatic logic [127:0] expect_word(input int pos);
    logic [127:0] w;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p1 = 32'(pos + 1);
      logic [31:0] kk = 32'(k);
      w[32*k +: 32] = (p1 * 32'h9E3779B9) ^ (kk * 32'h7F4A7C15);
    end
    return w;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model, updated on each edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_addr = 0; m_words = 0; m_werr = 0; m_berr = 0; m_done = 0;
    end else if (clear) begin
      m_addr = 0; m_words = 0; m_werr = 0; m_berr = 0; m_done = 0;
    end else if (in_valid) begin
      int ones;
      ones = $countones(in_data ^ expect_word(m_addr));
      m_words = (m_words < WMAX) ? m_words + 1 : WMAX;
      if (ones != 0) m_werr = (m_werr < WMAX) ? m_werr + 1 : WMAX;
      m_berr = (m_berr + ones > BMAX) ? BMAX : m_berr + ones;
      m_done = (m_addr == DEPTH - 1);
      m_addr = (m_addr == DEPTH - 1) ? 0 : m_addr + 1;
    end else begin
      m_done = 0;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 in_ready", int'(in_ready), int'(!clear));
      chk("R7 vec_addr", int'(vec_addr), m_addr);
      chk("R7 frame_done", int'(frame_done), int'(m_done));
      chk("R4 words_checked", int'(words_checked), m_words);
      chk("R5 word_errors", int'(word_errors), m_werr);
      chk("R6 bit_errors", int'(bit_errors), m_berr);
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic step(input logic v, input logic [127:0] mask, input logic c);
    @(posedge clk); #1;
    in_valid = v;
    clear    = c;
    in_data  = expect_word(m_addr) ^ mask;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs while reset is held
    chk("R1 reset addr", int'(vec_addr), 0);
    chk("R1 reset words", int'(words_checked), 0);
    chk("R1 reset bits", int'(bit_errors), 0);
    chk("R1 reset done", int'(frame_done), 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // R3 R4 R7: clean frame with idle gaps
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, '0, 1'b0);
      if (i % 4 == 3) step(1'b0, '0, 1'b0);
    end
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk("R3 clean frame no word errors", int'(word_errors), 0);
    chk("R4 frame words", int'(words_checked), DEPTH);
    chk("R7 wrapped addr", int'(vec_addr), 0);

    // R5 R6: single-bit, lane, and full inversions
    step(1'b1, 128'h1, 1'b0);
    step(1'b1, {96'h0, 32'hFFFF_FFFF}, 1'b0);
    step(1'b1, 128'h0, 1'b0);
    step(1'b1, {128{1'b1}}, 1'b0);
    step(1'b1, 128'h8000_0000_0000_0001_0000_0000_0000_0100, 1'b0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk("R5 word errors after mixed", int'(word_errors), 4);
    chk("R6 bit errors after mixed", int'(bit_errors), 1 + 32 + 128 + 3);

    // R9 R2: clear while a word is offered mid-frame
    step(1'b1, 128'h3, 1'b0);
    step(1'b1, 128'h3, 1'b1);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk("R9 clear addr", int'(vec_addr), 0);
    chk("R9 clear words", int'(words_checked), 0);
    chk("R9 clear bits", int'(bit_errors), 0);

    // R8: saturation with all-wrong words
    for (int i = 0; i < 300; i++) step(1'b1, {128{1'b1}}, 1'b0);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk("R8 words saturate", int'(words_checked), WMAX);
    chk("R8 word errors saturate", int'(word_errors), WMAX);
    chk("R8 bit errors saturate", int'(bit_errors), BMAX);

    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    @(negedge clk);
    chk("R9 clear after saturation", int'(word_errors), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule